// File: doc/BRIEF.md
# Multichannel RC Servo Pulse Generator

This block drives a bank of RC servo control outputs from a single system clock. Every period and pulse width is a count of 20 ns clock ticks, so a frame of 1,000,000 ticks lasts 20 ms. All channels share one frame counter and one frame-length register. Each channel has its own on-time register. At the start of every frame, each enabled channel raises its output and holds it high for its on-time.

Software reaches the block through a simple synchronous register port. A write takes effect at the clock edge on which `reg_we` is sampled high. A read is combinational from `reg_addr`. The configuration register holds one enable bit per channel and a separate global enable bit, and it reads back exactly as written, so firmware can toggle one channel with a read-modify-write. Frame-length and on-time writes are staged: the running frame finishes with the old values, and the new values are copied into working registers at the next frame boundary.

A two-state controller sequences the frame counter.
- `ST_HALT`: the counter is held at zero and all outputs are low.
- `ST_RUN`: the counter advances once per tick.

The controller has three transitions.
- GO (`ST_HALT` to `ST_RUN`): taken when the global enable is seen set. The staged values are loaded at this point.
- WRAP (`ST_RUN` to `ST_RUN`): taken on the last tick of a frame. The counter returns to zero and the staged values are reloaded.
- STOP (`ST_RUN` to `ST_HALT`): taken when the global enable is seen clear.

Top module: `servo_pulse_bank`

## Requirements
- R1: After reset, every register reads zero, all outputs are low and the controller is in `ST_HALT`.
- R2: While running with frame length P ticks, each frame lasts P ticks. An enabled channel is high on tick t of the frame (t counted from 0) exactly when t is below its on-time. A frame length of 0 behaves like 1.
- R3: A channel whose on-time is greater than or equal to the frame length stays high for every tick of every frame.
- R4: Register map by `reg_addr`:
  - Address 0 is the frame length.
  - Address 1 is the configuration register. Bit i enables channel i, bit DATA_W-1 is the global enable, and all other bits read zero.
  - Address 2+i is the on-time of channel i.
  - Each register reads back the value last written to it.
- R5: Any address at or above 2+N_CH reads zero, and a write to such an address changes no register and no output.
- R6: A write to the frame length or to an on-time while running does not alter the current frame. The new value applies from the next frame onward.
- R7: In the cycle after the edge that writes the global enable clear, all outputs are low and stay low, and the counter is held at zero. After the edge that writes it set, one idle cycle follows, and then a frame begins at tick 0.
- R8: In the cycle after the edge that clears a channel's enable bit, that channel is low. The other channels keep their timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 ns tick) |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| pulse_o | output | N_CH | Servo pulse outputs, one per channel |

## Verification
The bench builds the block with N_CH=3, DATA_W=8 and ADDR_W=3. With these values the global enable is bit 7, the map fills addresses 0 to 4, and addresses 5 to 7 are unmapped, so every address can be visited. Frames are only a few ticks long. This lets the bench sweep every frame length from 1 to 5 against every on-time from 0 to P+1, including on-times at and above the frame length. Each tick is checked against an expected value computed arithmetically. The short frames also make it cheap to land writes mid-frame, to test both the staged updates and the immediate effect of the enable bits.

// File: rtl/servo_pkg.sv
package servo_pkg;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } servo_state_e;

    localparam int unsigned ADDR_PERIOD  = 0;
    localparam int unsigned ADDR_CONFIG  = 1;
    localparam int unsigned ADDR_ON_BASE = 2;

endpackage

// File: rtl/servo_regfile.sv
module servo_regfile
    import servo_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [DATA_W-1:0]              period_o,
    output logic [N_CH-1:0][DATA_W-1:0]    on_o,
    output logic [N_CH-1:0]                ch_en_o,
    output logic                           glob_en_o
);
    localparam int GLOB_BIT = DATA_W - 1;

    logic [DATA_W-1:0]           period_q;
    logic [N_CH-1:0][DATA_W-1:0] on_q;
    logic [N_CH-1:0]             ch_en_q;
    logic                        glob_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            on_q     <= '0;
            ch_en_q  <= '0;
            glob_q   <= 1'b0;
        end else if (we) begin
            if (addr == ADDR_W'(ADDR_PERIOD)) begin
                period_q <= wdata;
            end
            if (addr == ADDR_W'(ADDR_CONFIG)) begin
                ch_en_q <= wdata[N_CH-1:0];
                glob_q  <= wdata[GLOB_BIT];
            end
            for (int i = 0; i < N_CH; i++) begin
                if (addr == ADDR_W'(ADDR_ON_BASE + i)) begin
                    on_q[i] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_PERIOD)) begin
            rdata = period_q;
        end
        if (addr == ADDR_W'(ADDR_CONFIG)) begin
            rdata[N_CH-1:0] = ch_en_q;
            rdata[GLOB_BIT] = glob_q;
        end
        for (int i = 0; i < N_CH; i++) begin
            if (addr == ADDR_W'(ADDR_ON_BASE + i)) begin
                rdata = on_q[i];
            end
        end
    end

    assign period_o  = period_q;
    assign on_o      = on_q;
    assign ch_en_o   = ch_en_q;
    assign glob_en_o = glob_q;

endmodule

// File: rtl/servo_frame_ctrl.sv
module servo_frame_ctrl
    import servo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_en,
    input  logic [DATA_W-1:0] period_in,
    output servo_state_e      state_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] act_period_o,
    output logic              load_o
);
    servo_state_e      state_q, state_d;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] act_period_q;
    logic              last_tick;
    logic              load;

    assign last_tick = (act_period_q <= DATA_W'(1)) ||
                       (cnt_q == act_period_q - DATA_W'(1));

    // next state and load strobe
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                if (glob_en) begin
                    state_d = ST_RUN;   // GO
                    load    = 1'b1;
                end
            end
            ST_RUN: begin
                if (!glob_en) begin
                    state_d = ST_HALT;  // STOP
                end else if (last_tick) begin
                    load    = 1'b1;     // WRAP
                end
            end
            default: state_d = ST_HALT;
        endcase
    end

    // state register with counter and staged period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_HALT;
            cnt_q        <= '0;
            act_period_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_HALT || load) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + DATA_W'(1);
            end
            if (load) begin
                act_period_q <= period_in;
            end
        end
    end

    assign state_o      = state_q;
    assign cnt_o        = cnt_q;
    assign act_period_o = act_period_q;
    assign load_o       = load;

endmodule

// File: rtl/servo_chan.sv
module servo_chan #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] on_in,
    input  logic              enable,
    input  logic              active,
    input  logic [DATA_W-1:0] cnt,
    output logic              pulse
);
    logic [DATA_W-1:0] act_on_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_on_q <= '0;
        end else if (load) begin
            act_on_q <= on_in;
        end
    end

    assign pulse = active && enable && (cnt < act_on_q);

endmodule

// File: rtl/servo_pulse_bank.sv
module servo_pulse_bank
    import servo_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [N_CH-1:0]   pulse_o
);
    logic [DATA_W-1:0]           period_reg;
    logic [N_CH-1:0][DATA_W-1:0] on_reg;
    logic [N_CH-1:0]             ch_en;
    logic                        glob_en;
    servo_state_e                state_q;
    logic [DATA_W-1:0]           frame_cnt;
    logic [DATA_W-1:0]           act_period;
    logic                        frame_load;
    logic                        run_active;

    servo_regfile #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .period_o  (period_reg),
        .on_o      (on_reg),
        .ch_en_o   (ch_en),
        .glob_en_o (glob_en)
    );

    servo_frame_ctrl #(.DATA_W(DATA_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .glob_en      (glob_en),
        .period_in    (period_reg),
        .state_o      (state_q),
        .cnt_o        (frame_cnt),
        .act_period_o (act_period),
        .load_o       (frame_load)
    );

    assign run_active = (state_q == ST_RUN) && glob_en;

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        servo_chan #(.DATA_W(DATA_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (frame_load),
            .on_in  (on_reg[g]),
            .enable (ch_en[g]),
            .active (run_active),
            .cnt    (frame_cnt),
            .pulse  (pulse_o[g])
        );
    end

endmodule

// File: rtl/servo_pulse_bank_chk.sv
module servo_pulse_bank_chk
    import servo_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [N_CH-1:0]   pulse_o,
    input servo_state_e      state,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] act_period
);
    localparam int NUM_REGS = int'(ADDR_ON_BASE) + N_CH;

    a_r7_halt_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HALT |-> cnt == '0);

    a_r7_halt_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HALT |-> pulse_o == '0);

    a_r2_cnt_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && act_period > DATA_W'(1)) |-> cnt < act_period);

    a_r2_cnt_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state == ST_RUN) && cnt != '0)
            |-> cnt == $past(cnt) + DATA_W'(1));

    a_r6_period_held_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state == ST_RUN) && cnt != '0)
            |-> $stable(act_period));

    a_r5_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        int'(reg_addr) >= NUM_REGS |-> reg_rdata == '0);

endmodule

bind servo_pulse_bank servo_pulse_bank_chk #(
    .N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .pulse_o    (pulse_o),
    .state      (state_q),
    .cnt        (frame_cnt),
    .act_period (act_period)
);

// File: tb/servo_pulse_bank_bench.sv
module servo_pulse_bank_bench;
    localparam int N  = 3;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam logic [DW-1:0] GLOB = 8'h80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [N-1:0]  pulse_o;

    int checks = 0;
    int errors = 0;

    servo_pulse_bank #(.N_CH(N), .DATA_W(DW), .ADDR_W(AW)) u_servo_pulse_bank (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pulse_o(pulse_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // called at a negedge; consumes one rising edge
    task automatic wr(input int a, input int d);
        reg_we    = 1'b1;
        reg_addr  = AW'(a);
        reg_wdata = DW'(d);
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = AW'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    function automatic logic [N-1:0] expv(input int tt, input int o0, input int o1,
                                          input int o2, input logic [N-1:0] en);
        logic [N-1:0] e;
        e[0] = en[0] && (tt < o0);
        e[1] = en[1] && (tt < o1);
        e[2] = en[2] && (tt < o2);
        return e;
    endfunction

    // halt, program, enable; returns at tick 0 of the first frame
    task automatic setup(input int p, input int o0, input int o1, input int o2,
                         input int cfg);
        wr(1, 0);
        wr(0, p);
        wr(2, o0);
        wr(3, o1);
        wr(4, o2);
        wr(1, cfg);
        chk(pulse_o == '0, "R7", "idle cycle after enable", int'(pulse_o), 0);
        @(negedge clk);
    endtask

    task automatic run_frames(input int p, input int o0, input int o1, input int o2,
                              input logic [N-1:0] en, input int frames, input string req);
        int pe;
        pe = (p < 1) ? 1 : p;
        for (int t = 0; t < frames * pe; t++) begin
            logic [N-1:0] e;
            e = expv(t % pe, o0, o1, o2, en);
            chk(pulse_o == e, req, $sformatf("P=%0d tick=%0d", p, t % pe),
                int'(pulse_o), int'(e));
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pulse_o == '0, "R1", "pulses in reset", int'(pulse_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd(a, d);
            chk(d == 0, "R1", $sformatf("reset read addr %0d", a), d, 0);
        end
        chk(pulse_o == '0, "R1", "pulses after reset", int'(pulse_o), 0);

        // R4: register map and readback
        wr(0, 8'h5A);
        wr(1, 8'h7F);
        wr(2, 8'h11);
        wr(3, 8'h22);
        wr(4, 8'h33);
        rd(0, d); chk(d == 8'h5A, "R4", "period readback", d, 8'h5A);
        rd(1, d); chk(d == 8'h07, "R4", "config unused bits zero", d, 8'h07);
        rd(2, d); chk(d == 8'h11, "R4", "on0 readback", d, 8'h11);
        rd(3, d); chk(d == 8'h22, "R4", "on1 readback", d, 8'h22);
        rd(4, d); chk(d == 8'h33, "R4", "on2 readback", d, 8'h33);
        chk(pulse_o == '0, "R7", "no output without global enable", int'(pulse_o), 0);
        wr(1, 8'hFF);
        rd(1, d); chk(d == 8'h87, "R4", "config with global", d, 8'h87);
        wr(1, 0);

        // R5: unmapped addresses
        for (int a = 5; a < 8; a++) wr(a, 8'hEE);
        for (int a = 5; a < 8; a++) begin
            rd(a, d);
            chk(d == 0, "R5", $sformatf("unmapped read %0d", a), d, 0);
        end
        rd(0, d); chk(d == 8'h5A, "R5", "period untouched", d, 8'h5A);
        rd(1, d); chk(d == 0, "R5", "config untouched", d, 0);
        rd(4, d); chk(d == 8'h33, "R5", "on2 untouched", d, 8'h33);
        chk(pulse_o == '0, "R5", "outputs untouched", int'(pulse_o), 0);

        // R2 and R3: sweep of frame length against on-time
        for (int p = 1; p <= 5; p++) begin
            for (int b = 0; b < p + 2; b++) begin
                int o0, o1, o2;
                o0 = b % (p + 2);
                o1 = (b + 1) % (p + 2);
                o2 = (b + 2) % (p + 2);
                setup(p, o0, o1, o2, 8'h87);
                run_frames(p, o0, o1, o2, 3'b111, 2,
                           (o0 >= p || o1 >= p || o2 >= p) ? "R3" : "R2");
            end
        end

        // R2: frame length 0 behaves as 1
        setup(0, 1, 0, 1, 8'h87);
        run_frames(0, 1, 0, 1, 3'b111, 3, "R2");

        // R5: unmapped write while running changes nothing
        setup(4, 2, 3, 1, 8'h87);
        wr(6, 8'h00);
        run_frames(4, 2, 3, 1, 3'b111, 0, "R5");
        chk(pulse_o == 3'b011, "R5", "tick 1 after unmapped write", int'(pulse_o), 3'b011);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        run_frames(4, 2, 3, 1, 3'b111, 1, "R5");

        // R6: staged on-time
        setup(4, 2, 2, 2, 8'h87);
        chk(pulse_o == 3'b111, "R6", "tick 0", int'(pulse_o), 3'b111);
        wr(2, 3);
        chk(pulse_o == 3'b111, "R6", "tick 1 old on", int'(pulse_o), 3'b111);
        @(negedge clk);
        chk(pulse_o == 3'b000, "R6", "tick 2 old on", int'(pulse_o), 3'b000);
        @(negedge clk);
        chk(pulse_o == 3'b000, "R6", "tick 3 old on", int'(pulse_o), 3'b000);
        @(negedge clk);
        run_frames(4, 3, 2, 2, 3'b111, 1, "R6");
        // R6: staged frame length
        chk(pulse_o == 3'b111, "R6", "tick 0 before period write", int'(pulse_o), 3'b111);
        wr(0, 6);
        chk(pulse_o == 3'b111, "R6", "tick 1 old period", int'(pulse_o), 3'b111);
        @(negedge clk);
        chk(pulse_o == 3'b001, "R6", "tick 2 old period", int'(pulse_o), 3'b001);
        @(negedge clk);
        chk(pulse_o == 3'b000, "R6", "tick 3 old period", int'(pulse_o), 3'b000);
        @(negedge clk);
        run_frames(6, 3, 2, 2, 3'b111, 2, "R6");

        // R8: per-channel enable
        setup(5, 3, 3, 3, 8'h87);
        wr(1, 8'h85);
        chk(pulse_o == 3'b101, "R8", "tick 1 ch1 off", int'(pulse_o), 3'b101);
        @(negedge clk);
        chk(pulse_o == 3'b101, "R8", "tick 2 ch1 off", int'(pulse_o), 3'b101);
        @(negedge clk);
        chk(pulse_o == 3'b000, "R8", "tick 3", int'(pulse_o), 3'b000);
        @(negedge clk);
        chk(pulse_o == 3'b000, "R8", "tick 4", int'(pulse_o), 3'b000);
        @(negedge clk);
        run_frames(5, 3, 3, 3, 3'b101, 2, "R8");

        // R7: global clear and restart from tick 0
        setup(5, 4, 2, 5, 8'h87);
        @(negedge clk);
        wr(1, 8'h07);
        chk(pulse_o == 3'b000, "R7", "low after global clear", int'(pulse_o), 0);
        repeat (7) begin
            @(negedge clk);
            chk(pulse_o == 3'b000, "R7", "held low", int'(pulse_o), 0);
        end
        rd(1, d); chk(d == 8'h07, "R7", "enables kept", d, 8'h07);
        wr(1, 8'h87);
        chk(pulse_o == 3'b000, "R7", "idle cycle on restart", int'(pulse_o), 0);
        @(negedge clk);
        run_frames(5, 4, 2, 5, 3'b111, 2, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule